// File: doc/BRIEF.md
# Pipelined Min-Priority Queue

This block holds up to 2^LEVELS-1 keys in a binary min-heap that is stored one tree level per register bank. Each level has its own pipeline stage, so the caller may issue one operation in every clock cycle, with no stall and no handshake. The two operations are inserting a key and removing the smallest key. The current smallest key is always on `min_key`, and `empty` and `full` report occupancy.

Both operations walk from the root towards the leaves and change only one level per cycle. An insert keeps the smaller of its carried key and the stored key at each node and carries the larger one on. It follows per-node vacancy counts to a free slot. A delete removes the root and pulls the smaller child up into each hole, one level per cycle. A hole that reaches a node with no occupied children is marked empty. When a delete reads a child that the operation one stage ahead writes in the same cycle, the value being written is forwarded. The visible results are therefore those of a queue that finishes each operation before it starts the next.

Top module: `heap_pipe`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `err` is 0.
- R2: An accepted insert makes `min_key` equal, in the next cycle, to the smaller of the new key and the previous minimum (or the new key if the queue was empty).
- R3: An accepted delete removes one copy of the smallest key. In the next cycle `min_key` shows the smallest remaining key, unless the queue is now empty.
- R4: Operations may be issued in consecutive cycles without gaps. After each one, `min_key`, `empty` and `full` equal those of a sequential priority queue given the same sequence.
- R5: `empty` is 1 exactly when no key is held, and `full` is 1 exactly when 2^LEVELS-1 keys are held (31 with LEVELS=5).
- R6: An insert request while `full` is 1 changes nothing, and `err` is 1 in the next cycle.
- R7: A delete request while `empty` is 1 changes nothing, and `err` is 1 in the next cycle.
- R8: Raising `ins_req` and `del_req` in the same cycle performs neither operation, and `err` is 1 in the next cycle. In every other case `err` is 0 in the next cycle.
- R9: Equal keys are held as separate entries, and each delete removes only one of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_req | input | 1 | Insert `ins_key` this cycle |
| del_req | input | 1 | Remove the smallest key this cycle |
| ins_key | input | KW | Key to insert |
| min_key | output | KW | Smallest key held (valid while not empty) |
| empty | output | 1 | No key held |
| full | output | 1 | Capacity reached |
| err | output | 1 | One-cycle pulse: the previous request was refused |

## Verification
The hazard of interest is a delete that reads two children in the same cycle that the operation one stage ahead writes one of them. That older operation may be an insert settling its key there, or a delete pulling a grandchild up. Runs of back-to-back inserts followed at once by back-to-back deletes provoke this hazard, as does a long random mix of single-cycle requests with small key values so that many keys are equal. After every cycle, the minimum and the flags are compared with a reference queue kept in the bench, so a stale child value shows up as a wrong minimum several deletes later. Refused and conflicting requests are mixed in to confirm that they leave the queue untouched.

// File: rtl/heap_pipe.sv
module heap_pipe #(
  parameter int LEVELS = 5,
  parameter int KW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_req,
  input  logic          del_req,
  input  logic [KW-1:0] ins_key,
  output logic [KW-1:0] min_key,
  output logic          empty,
  output logic          full,
  output logic          err
);
  localparam int CAP = (1 << LEVELS) - 1;
  localparam int LW  = LEVELS;

  logic [KW-1:0] key_q [CAP];
  logic          occ_q [CAP];
  logic [LW-1:0] vl_q  [CAP];
  logic [LW-1:0] vr_q  [CAP];
  logic [LW-1:0] cnt_q;
  logic          err_q;

  logic          p_v   [LEVELS];
  logic          p_ins [LEVELS];
  logic [LW-1:0] p_idx [LEVELS];
  logic [KW-1:0] p_key [LEVELS];

  logic          wen  [LEVELS];
  logic          wocc [LEVELS];
  logic [LW-1:0] widx [LEVELS];
  logic [KW-1:0] wkey [LEVELS];
  logic          nv   [LEVELS];
  logic          nins [LEVELS];
  logic [LW-1:0] nidx [LEVELS];
  logic [KW-1:0] nkey [LEVELS];
  logic          vinc [LEVELS];
  logic          vdec [LEVELS];
  logic          vsd  [LEVELS];

  logic          cv, ci, lo, ro, go_left;
  logic [LW-1:0] cx, lc, rc;
  logic [KW-1:0] ck, lk, rk;

  logic acc_ins, acc_del, bad;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == LW'(CAP));
  assign acc_ins = ins_req && !del_req && !full;
  assign acc_del = del_req && !ins_req && !empty;
  assign bad     = (ins_req || del_req) && !acc_ins && !acc_del;
  assign min_key = key_q[0];
  assign err     = err_q;

  function automatic logic [LW-1:0] vac_init(input int i);
    int lv;
    lv = $clog2(i + 2) - 1;
    return LW'((1 << (LEVELS - 1 - lv)) - 1);
  endfunction

  always_comb begin
    for (int s = LEVELS - 1; s >= 0; s--) begin
      cv = (s == 0) ? (acc_ins || acc_del) : p_v[s];
      ci = (s == 0) ? acc_ins : p_ins[s];
      cx = (s == 0) ? '0 : p_idx[s];
      ck = (s == 0) ? ins_key : p_key[s];
      lc = {cx[LW-2:0], 1'b1};
      rc = lc + 1'b1;
      lk = '0; rk = '0; lo = 1'b0; ro = 1'b0; go_left = 1'b1;
      wen[s]  = 1'b0; wocc[s] = 1'b0; widx[s] = cx; wkey[s] = ck;
      nv[s]   = 1'b0; nins[s] = ci;   nidx[s] = cx; nkey[s] = ck;
      vinc[s] = 1'b0; vdec[s] = 1'b0; vsd[s]  = 1'b0;
      if (s < LEVELS - 1) begin
        lk = key_q[lc]; lo = occ_q[lc];
        rk = key_q[rc]; ro = occ_q[rc];
        if (wen[(s+1)%LEVELS] && widx[(s+1)%LEVELS] == lc) begin
          lk = wkey[(s+1)%LEVELS]; lo = wocc[(s+1)%LEVELS];
        end
        if (wen[(s+1)%LEVELS] && widx[(s+1)%LEVELS] == rc) begin
          rk = wkey[(s+1)%LEVELS]; ro = wocc[(s+1)%LEVELS];
        end
        go_left = lo && (!ro || lk <= rk);
      end
      if (cv) begin
        wen[s] = 1'b1;
        if (ci) begin
          wocc[s] = 1'b1;
          if (occ_q[cx] && s < LEVELS - 1) begin
            wkey[s] = (ck < key_q[cx]) ? ck : key_q[cx];
            nkey[s] = (ck < key_q[cx]) ? key_q[cx] : ck;
            nv[s]   = 1'b1;
            vsd[s]  = (vl_q[cx] == '0);
            vdec[s] = 1'b1;
            nidx[s] = (vl_q[cx] == '0) ? rc : lc;
          end
        end else if (s < LEVELS - 1 && (lo || ro)) begin
          wocc[s] = 1'b1;
          wkey[s] = go_left ? lk : rk;
          vinc[s] = 1'b1;
          vsd[s]  = !go_left;
          nv[s]   = 1'b1;
          nidx[s] = go_left ? lc : rc;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
      for (int i = 0; i < CAP; i++) begin
        key_q[i] <= '0;
        occ_q[i] <= 1'b0;
        vl_q[i]  <= vac_init(i);
        vr_q[i]  <= vac_init(i);
      end
      for (int s = 0; s < LEVELS; s++) begin
        p_v[s] <= 1'b0; p_ins[s] <= 1'b0; p_idx[s] <= '0; p_key[s] <= '0;
      end
    end else begin
      err_q <= bad;
      if (acc_ins) cnt_q <= cnt_q + 1'b1;
      else if (acc_del) cnt_q <= cnt_q - 1'b1;
      p_v[0] <= 1'b0;
      for (int s = 0; s < LEVELS - 1; s++) begin
        p_v[s+1]   <= nv[s];
        p_ins[s+1] <= nins[s];
        p_idx[s+1] <= nidx[s];
        p_key[s+1] <= nkey[s];
      end
      for (int s = 0; s < LEVELS; s++) begin
        if (wen[s]) begin
          key_q[widx[s]] <= wkey[s];
          occ_q[widx[s]] <= wocc[s];
        end
        if (vdec[s]) begin
          if (vsd[s]) vr_q[widx[s]] <= vr_q[widx[s]] - 1'b1;
          else        vl_q[widx[s]] <= vl_q[widx[s]] - 1'b1;
        end else if (vinc[s]) begin
          if (vsd[s]) vr_q[widx[s]] <= vr_q[widx[s]] + 1'b1;
          else        vl_q[widx[s]] <= vl_q[widx[s]] + 1'b1;
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= LW'(CAP)); // R5
  AST_ROOT_OCC: assert property (@(posedge clk) disable iff (!rst_n) occ_q[0] == !empty); // R3
  AST_INS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ins && !empty) |=> min_key == (($past(ins_key) < $past(min_key)) ? $past(ins_key) : $past(min_key))); // R2
  AST_DEL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_del |=> (empty || min_key >= $past(min_key))); // R3
  AST_ERR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && !del_req && full) |=> err); // R6
  AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (del_req && !ins_req && empty) |=> err); // R7
  AST_REFUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && del_req) |=> ($stable(cnt_q) && err)); // R8
endmodule

// File: tb/heap_pipe_bench.sv
module heap_pipe_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEVELS     = 5;
  localparam int KW         = 16;
  localparam int CAP        = (1 << LEVELS) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ins_req = 1'b0;
  logic          del_req = 1'b0;
  logic [KW-1:0] ins_key = '0;
  logic [KW-1:0] min_key;
  logic          empty, full, err;

  heap_pipe #(.LEVELS(LEVELS), .KW(KW)) u_heap_pipe (
    .clk(clk), .rst_n(rst_n), .ins_req(ins_req), .del_req(del_req),
    .ins_key(ins_key), .min_key(min_key), .empty(empty), .full(full), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 0;
  logic [KW-1:0] m [CAP];
  int            mcnt = 0;
  bit            exp_err = 0;

  function automatic int model_min();
    int best = 0;
    for (int j = 1; j < mcnt; j++) if (m[j] < m[best]) best = j;
    return best;
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic verify(input string tag);
    check(empty == (mcnt == 0), tag, "empty", empty, mcnt == 0);
    check(full == (mcnt == CAP), tag, "full", full, mcnt == CAP);
    check(err == exp_err, tag, "err", err, exp_err);
    if (mcnt > 0) check(min_key == m[model_min()], tag, "min_key", min_key, m[model_min()]);
  endtask

  task automatic apply(input bit i, input bit d, input logic [KW-1:0] k, input string tag);
    ins_req = i; del_req = d; ins_key = k;
    exp_err = 0;
    if (i && d) exp_err = 1;
    else if (i) begin
      if (mcnt < CAP) begin m[mcnt] = k; mcnt++; end
      else exp_err = 1;
    end else if (d) begin
      if (mcnt > 0) begin
        int j = model_min();
        m[j] = m[mcnt-1];
        mcnt--;
      end else exp_err = 1;
    end
    @(negedge clk);
    ins_req = 0; del_req = 0;
    verify(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    verify("R1");
    // R7: delete on empty queue
    apply(0, 1, 16'd0, "R7");
    // R2: descending keys lower the minimum each time
    for (int k = 20; k > 10; k--) apply(1, 0, KW'(k), "R2");
    apply(1, 0, 16'd30, "R2");
    // R9: duplicates
    for (int k = 0; k < 3; k++) apply(1, 0, 16'd5, "R9");
    apply(0, 1, 16'd0, "R9");
    apply(0, 1, 16'd0, "R9");
    // R8: both requested
    apply(1, 1, 16'd1, "R8");
    // R5: fill to capacity back-to-back
    while (mcnt < CAP) apply(1, 0, KW'($urandom_range(0, 40)), "R5");
    // R6: insert while full, key smaller than everything
    apply(1, 0, 16'd0, "R6");
    apply(1, 0, 16'd0, "R6");
    // R3: drain back-to-back
    while (mcnt > 0) apply(0, 1, 16'd0, "R3");
    apply(0, 1, 16'd0, "R7");
    // R4: interleaved insert/delete every cycle
    for (int k = 0; k < 20; k++) begin
      apply(1, 0, KW'(50 - k), "R4");
      apply(1, 0, KW'(k), "R4");
      apply(0, 1, 16'd0, "R4");
    end
    // R4: random mix with phases biased to fill and drain
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      int bias = ((n / 250) % 2 == 0) ? 60 : 35;
      if (r < bias) apply(1, 0, KW'($urandom_range(0, 15)), "R4");
      else if (r < 96) apply(0, 1, 16'd0, "R4");
      else if (r < 98) apply(1, 1, KW'($urandom_range(0, 15)), "R8");
      else apply(0, 0, 16'd0, "R4");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule